// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Controller

This block sits beside an 8-bit processor core. It keeps the core's interrupt state: the primary and backup enable flags, the interrupt mode, the halt state, and the blocking of maskable requests at the boundary of an enable or disable instruction. At each instruction boundary it decides whether to take an interrupt. A non-maskable request is always taken and wins over a maskable one. A maskable request is taken only when the primary enable is set.

Once it takes an interrupt, the block runs a short fixed sequence. First it emits the return address as two stack write bytes. For a table-mode interrupt it then issues two table reads. Last it presents the new program counter with a one-cycle valid. The core stalls until that valid, and the block ignores boundary strobes while the sequence runs. If the core was halted, the return address points one past the halt instruction. This works because a halted core keeps presenting the halt instruction's own address.

Top module: `irq_accept_ctl`

## Requirements
- R1: At a boundary (`instrDone`=1 while idle), a maskable request with `nmiReq`=0 is taken only if `iff1Out` was 1 before that boundary. `ackPulse` rises one cycle after the boundary.
- R2: A non-maskable request at a boundary is always taken, whatever the enables are, and it wins over a maskable request at the same boundary.
- R3: On acceptance the backup enable `iff2Out` takes the primary enable as left by that boundary's instruction, and `iff1Out` clears. `eiStrobe` sets both flags, and `diStrobe` clears both. If both strobes are present, `eiStrobe` wins.
- R4: In the `ackPulse` cycle the block writes the return address high byte (`stkWrEn`=1, `stkWrHigh`=1). In the next cycle it writes the low byte (`stkWrHigh`=0).
- R5: `haltStrobe` at a boundary sets `halted`. If `halted` or `haltStrobe` is set when an interrupt is taken, the return address is `pcIn`+1 and `halted` clears. Otherwise the return address is `pcIn`.
- R6: The target of a non-maskable interrupt is 0x0066.
- R7: In mode 2 the block reads the table at {`pageReg`,`irqVector`} and then at that address plus 1, with 16-bit wrap, on two consecutive `tblRdEn` cycles. `tblData` returns one cycle after each read. The first byte is the target low byte and the second is the high byte.
- R8: In mode 1 the target is 0x0038. In mode 0 the target is {0x00,`irqVector`}.
- R9: A maskable request at a boundary that carries `eiStrobe` or `diStrobe` is not taken. A request after `eiStrobe` is taken at the following boundary.
- R10: `modeStrobe` at a boundary loads `modeSel` codes 0, 1 or 2 into `intMode`. Code 3 leaves `intMode` unchanged. An interrupt taken at that boundary uses the new mode.
- R11: After reset, both enables are 0, `intMode` is 0, `halted` is 0, `tgtPc` is 0x0000, and `ackPulse`, `stkWrEn`, `tblRdEn` and `tgtValid` are low.
- R12: `tgtValid` pulses 3 cycles after the accepting boundary for modes 0 and 1 and for a non-maskable interrupt, and 6 cycles after it for mode 2. All strobes arriving before then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Instruction boundary strobe |
| pcIn | input | 16 | Next instruction address at the boundary (the halt's own address while halted) |
| eiStrobe | input | 1 | Boundary instruction was an enable |
| diStrobe | input | 1 | Boundary instruction was a disable |
| haltStrobe | input | 1 | Boundary instruction was a halt |
| modeStrobe | input | 1 | Boundary instruction selects a mode |
| modeSel | input | 2 | Mode code to select |
| irqReq | input | 1 | Maskable request |
| irqVector | input | 8 | Vector byte of the maskable request |
| nmiReq | input | 1 | Non-maskable request |
| pageReg | input | 8 | Interrupt page register |
| tblData | input | 8 | Table read data, one cycle after the read |
| ackPulse | output | 1 | Interrupt taken (first push cycle) |
| stkWrEn | output | 1 | Stack byte write |
| stkWrHigh | output | 1 | Written byte is the high byte |
| stkWrByte | output | 8 | Return address byte |
| tblRdEn | output | 1 | Table read request |
| tblAddr | output | 16 | Table read address |
| tgtValid | output | 1 | New program counter valid |
| tgtPc | output | 16 | New program counter |
| iff1Out | output | 1 | Primary enable |
| iff2Out | output | 1 | Backup enable |
| halted | output | 1 | Halt state |
| intMode | output | 2 | Current interrupt mode |

## Verification
The bench targets these corner cases:
- A request at the boundary of an enable instruction. A design without the delay would acknowledge it one instruction early.
- A non-maskable request taken while disabled and halted. A wrong design would keep a stale backup enable, or push the halt's own address and loop on the halt forever.
- A mode-2 table at page 0xFF, vector 0xFF. Here the second read must wrap to 0x0000, and a byte-order mistake shows up as a swapped target.
- A burst of request, halt and disable strobes held during a running sequence. A design that listens while busy would acknowledge twice or corrupt its flags.

// File: rtl/irq_accept_pkg.sv
`timescale 1ns/1ps
package irq_accept_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_HI, S_PUSH_LO, S_TBL_LO, S_TBL_HI, S_TBL_END, S_DONE
  } ctlState_t;

  typedef enum logic [1:0] {
    K_NMI, K_FIXED, K_DIRECT, K_TABLE
  } tgtKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchCtx;  // capture return address, vector and page
    logic     bumpRet;   // return address skips the halt instruction
    logic     pushHi;    // select high return byte
    logic     rdHi;      // second table address
    logic     capLo;     // capture table low byte
    logic     loadTgt;   // update target register
    tgtKind_t kind;
  } dpStrobe_t;

  localparam logic [1:0] MODE_RESERVED = 2'd3;

endpackage

// File: rtl/irq_accept_ctrl.sv
`timescale 1ns/1ps
module irq_accept_ctrl
  import irq_accept_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       eiStrobe,
  input  logic       diStrobe,
  input  logic       haltStrobe,
  input  logic       modeStrobe,
  input  logic [1:0] modeSel,
  input  logic       irqReq,
  input  logic       nmiReq,
  output dpStrobe_t  strb,
  output logic       ackPulse,
  output logic       stkWrEn,
  output logic       stkWrHigh,
  output logic       tblRdEn,
  output logic       tgtValid,
  output logic       iff1Out,
  output logic       iff2Out,
  output logic       halted,
  output logic [1:0] intMode
);

  ctlState_t st, stNxt;
  tgtKind_t  kind, kindNxt;
  logic      iff1, iff2, haltR;
  logic [1:0] mode, modeNxt;
  logic      boundary, iffEff, takeNmi, takeIrq, take;

  always_comb begin
    boundary = instrDone && (st == S_IDLE);
    iffEff   = eiStrobe ? 1'b1 : (diStrobe ? 1'b0 : iff1);
    modeNxt  = (modeStrobe && modeSel != MODE_RESERVED) ? modeSel : mode;
    takeNmi  = boundary && nmiReq;
    takeIrq  = boundary && !nmiReq && irqReq && iff1 && !eiStrobe && !diStrobe;
    take     = takeNmi || takeIrq;
    if (takeNmi)            kindNxt = K_NMI;
    else if (modeNxt == 2'd1) kindNxt = K_FIXED;
    else if (modeNxt == 2'd2) kindNxt = K_TABLE;
    else                    kindNxt = K_DIRECT;
  end

  always_comb begin
    stNxt = st;
    unique case (st)
      S_IDLE:    stNxt = take ? S_PUSH_HI : S_IDLE;
      S_PUSH_HI: stNxt = S_PUSH_LO;
      S_PUSH_LO: stNxt = (kind == K_TABLE) ? S_TBL_LO : S_DONE;
      S_TBL_LO:  stNxt = S_TBL_HI;
      S_TBL_HI:  stNxt = S_TBL_END;
      S_TBL_END: stNxt = S_DONE;
      S_DONE:    stNxt = S_IDLE;
      default:   stNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= S_IDLE;
      kind  <= K_DIRECT;
      iff1  <= 1'b0;
      iff2  <= 1'b0;
      haltR <= 1'b0;
      mode  <= 2'd0;
    end else begin
      st <= stNxt;
      if (boundary) mode <= modeNxt;
      if (take) begin
        iff1  <= 1'b0;
        iff2  <= iffEff;
        haltR <= 1'b0;
        kind  <= kindNxt;
      end else if (boundary) begin
        if (eiStrobe || diStrobe) begin
          iff1 <= iffEff;
          iff2 <= iffEff;
        end
        if (haltStrobe) haltR <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.latchCtx = take;
    strb.bumpRet  = haltR || haltStrobe;
    strb.pushHi   = (st == S_PUSH_HI);
    strb.rdHi     = (st == S_TBL_HI);
    strb.capLo    = (st == S_TBL_HI);
    strb.loadTgt  = ((st == S_PUSH_LO) && (kind != K_TABLE)) || (st == S_TBL_END);
    strb.kind     = kind;
  end

  assign ackPulse  = (st == S_PUSH_HI);
  assign stkWrEn   = (st == S_PUSH_HI) || (st == S_PUSH_LO);
  assign stkWrHigh = (st == S_PUSH_HI);
  assign tblRdEn   = (st == S_TBL_LO) || (st == S_TBL_HI);
  assign tgtValid  = (st == S_DONE);
  assign iff1Out   = iff1;
  assign iff2Out   = iff2;
  assign halted    = haltR;
  assign intMode   = mode;

endmodule

// File: rtl/irq_accept_dp.sv
`timescale 1ns/1ps
module irq_accept_dp
  import irq_accept_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] NMI_TARGET = 'h0066,
  parameter logic [2*DW-1:0] RST_TARGET = 'h0038
)(
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strb,
  input  logic [2*DW-1:0] pcIn,
  input  logic [DW-1:0]   irqVector,
  input  logic [DW-1:0]   pageReg,
  input  logic [DW-1:0]   tblData,
  output logic [DW-1:0]   stkWrByte,
  output logic [2*DW-1:0] tblAddr,
  output logic [2*DW-1:0] tgtPc
);

  localparam int AW = 2 * DW;

  logic [AW-1:0] retAddr, tgtR;
  logic [DW-1:0] vecR, pageR, loR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retAddr <= '0;
      vecR    <= '0;
      pageR   <= '0;
      loR     <= '0;
      tgtR    <= '0;
    end else begin
      if (strb.latchCtx) begin
        retAddr <= strb.bumpRet ? pcIn + AW'(1) : pcIn;
        vecR    <= irqVector;
        pageR   <= pageReg;
      end
      if (strb.capLo) loR <= tblData;
      if (strb.loadTgt) begin
        unique case (strb.kind)
          K_NMI:    tgtR <= NMI_TARGET;
          K_FIXED:  tgtR <= RST_TARGET;
          K_DIRECT: tgtR <= {{DW{1'b0}}, vecR};
          K_TABLE:  tgtR <= {tblData, loR};
          default:  tgtR <= '0;
        endcase
      end
    end
  end

  assign stkWrByte = strb.pushHi ? retAddr[AW-1:DW] : retAddr[DW-1:0];
  assign tblAddr   = {pageR, vecR} + AW'(strb.rdHi);
  assign tgtPc     = tgtR;

endmodule

// File: rtl/irq_accept_ctl.sv
`timescale 1ns/1ps
module irq_accept_ctl
  import irq_accept_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] NMI_TARGET = 'h0066,
  parameter logic [2*DW-1:0] RST_TARGET = 'h0038
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrDone,
  input  logic [2*DW-1:0] pcIn,
  input  logic            eiStrobe,
  input  logic            diStrobe,
  input  logic            haltStrobe,
  input  logic            modeStrobe,
  input  logic [1:0]      modeSel,
  input  logic            irqReq,
  input  logic [DW-1:0]   irqVector,
  input  logic            nmiReq,
  input  logic [DW-1:0]   pageReg,
  input  logic [DW-1:0]   tblData,
  output logic            ackPulse,
  output logic            stkWrEn,
  output logic            stkWrHigh,
  output logic [DW-1:0]   stkWrByte,
  output logic            tblRdEn,
  output logic [2*DW-1:0] tblAddr,
  output logic            tgtValid,
  output logic [2*DW-1:0] tgtPc,
  output logic            iff1Out,
  output logic            iff2Out,
  output logic            halted,
  output logic [1:0]      intMode
);

  dpStrobe_t strb;

  irq_accept_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone),
    .eiStrobe(eiStrobe), .diStrobe(diStrobe), .haltStrobe(haltStrobe),
    .modeStrobe(modeStrobe), .modeSel(modeSel),
    .irqReq(irqReq), .nmiReq(nmiReq), .strb(strb),
    .ackPulse(ackPulse), .stkWrEn(stkWrEn), .stkWrHigh(stkWrHigh),
    .tblRdEn(tblRdEn), .tgtValid(tgtValid),
    .iff1Out(iff1Out), .iff2Out(iff2Out), .halted(halted), .intMode(intMode)
  );

  irq_accept_dp #(.DW(DW), .NMI_TARGET(NMI_TARGET), .RST_TARGET(RST_TARGET)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn),
    .irqVector(irqVector), .pageReg(pageReg), .tblData(tblData),
    .stkWrByte(stkWrByte), .tblAddr(tblAddr), .tgtPc(tgtPc)
  );

endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk #(
  parameter int DW = 8
)(
  input logic            clk,
  input logic            rstN,
  input logic            nmiReq,
  input logic            eiStrobe,
  input logic            ackPulse,
  input logic            stkWrEn,
  input logic            stkWrHigh,
  input logic            tblRdEn,
  input logic [2*DW-1:0] tblAddr,
  input logic            tgtValid,
  input logic            iff1Out,
  input logic            halted,
  input logic [1:0]      intMode
);

  p_irq_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && !$past(nmiReq)) |-> ($past(iff1Out) && !$past(eiStrobe)));

  p_ack_clears_iff_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !iff1Out);

  p_ack_high_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (stkWrEn && stkWrHigh));

  p_push_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stkWrEn && stkWrHigh) |=> (stkWrEn && !stkWrHigh));

  p_ack_unhalts_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !halted);

  p_tbl_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tblRdEn && $past(tblRdEn)) |-> (tblAddr == $past(tblAddr) + (2*DW)'(1)));

  p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    intMode != 2'd3);

  p_tgt_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> (!stkWrEn && !tblRdEn && !ackPulse));

endmodule

bind irq_accept_ctl irq_accept_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .eiStrobe(eiStrobe),
  .ackPulse(ackPulse), .stkWrEn(stkWrEn), .stkWrHigh(stkWrHigh),
  .tblRdEn(tblRdEn), .tblAddr(tblAddr), .tgtValid(tgtValid),
  .iff1Out(iff1Out), .halted(halted), .intMode(intMode)
);

// File: tb/irq_accept_ctl_bench.sv
`timescale 1ns/1ps
module irq_accept_ctl_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrDone, eiStrobe, diStrobe, haltStrobe, modeStrobe;
  logic [1:0]  modeSel;
  logic        irqReq, nmiReq;
  logic [15:0] pcIn;
  logic [7:0]  irqVector, pageReg, tblData;
  logic        ackPulse, stkWrEn, stkWrHigh, tblRdEn, tgtValid;
  logic [7:0]  stkWrByte;
  logic [15:0] tblAddr, tgtPc;
  logic        iff1Out, iff2Out, halted;
  logic [1:0]  intMode;

  int nChk = 0;
  int nFail = 0;

  // bench model state
  logic       mIff1, mIff2, mHalt;
  logic [1:0] mMode;

  always #2.5 clk = ~clk;

  irq_accept_ctl u_irq_accept_ctl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .pcIn(pcIn),
    .eiStrobe(eiStrobe), .diStrobe(diStrobe), .haltStrobe(haltStrobe),
    .modeStrobe(modeStrobe), .modeSel(modeSel), .irqReq(irqReq),
    .irqVector(irqVector), .nmiReq(nmiReq), .pageReg(pageReg),
    .tblData(tblData), .ackPulse(ackPulse), .stkWrEn(stkWrEn),
    .stkWrHigh(stkWrHigh), .stkWrByte(stkWrByte), .tblRdEn(tblRdEn),
    .tblAddr(tblAddr), .tgtValid(tgtValid), .tgtPc(tgtPc),
    .iff1Out(iff1Out), .iff2Out(iff2Out), .halted(halted), .intMode(intMode)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  // vector table memory, one cycle read latency
  always_ff @(posedge clk) if (tblRdEn) tblData <= memFn(tblAddr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setIn(input logic busy);
    instrDone  = busy; nmiReq = busy; irqReq = busy;
    haltStrobe = busy; diStrobe = busy; eiStrobe = 1'b0;
    modeStrobe = busy; modeSel = 2'd0;
  endtask

  task automatic boundary(input logic [15:0] pc, input logic irq, input logic [7:0] vec,
                          input logic nmi, input logic ei, input logic di, input logic hlt,
                          input logic ms, input logic [1:0] msel, input logic [7:0] pg,
                          input logic noise);
    logic iffEff, take;
    logic [1:0] modeEff;
    logic [15:0] ret, tgt, base;
    int kind; // 0 nmi, 1 fixed, 2 direct, 3 table
    iffEff  = ei ? 1'b1 : (di ? 1'b0 : mIff1);
    modeEff = (ms && msel != 2'd3) ? msel : mMode;
    take    = nmi || (irq && mIff1 && !ei && !di);
    ret     = (mHalt || hlt) ? pc + 16'd1 : pc;
    base    = {pg, vec};
    kind    = nmi ? 0 : (modeEff == 2'd1 ? 1 : (modeEff == 2'd2 ? 3 : 2));
    tgt     = (kind == 0) ? 16'h0066 : (kind == 1) ? 16'h0038 :
              (kind == 2) ? {8'h00, vec} : {memFn(base + 16'd1), memFn(base)};
    mMode   = modeEff;
    if (take) begin
      mIff2 = iffEff; mIff1 = 1'b0; mHalt = 1'b0;
    end else begin
      if (ei || di) begin mIff1 = iffEff; mIff2 = iffEff; end
      if (hlt) mHalt = 1'b1;
    end

    instrDone = 1'b1; pcIn = pc; irqReq = irq; irqVector = vec; nmiReq = nmi;
    eiStrobe = ei; diStrobe = di; haltStrobe = hlt; modeStrobe = ms;
    modeSel = msel; pageReg = pg;
    @(posedge clk); @(negedge clk);
    chk(take ? (nmi ? "R2 ack" : "R1 ack") : "R1/R9 no ack", {31'd0, ackPulse}, {31'd0, take});
    chk("R3 iff1", {31'd0, iff1Out}, {31'd0, mIff1});
    chk("R3 iff2", {31'd0, iff2Out}, {31'd0, mIff2});
    chk("R5 halted", {31'd0, halted}, {31'd0, mHalt});
    chk("R10 mode", {30'd0, intMode}, {30'd0, mMode});
    if (!take) begin
      setIn(1'b0);
      return;
    end
    chk("R4 hi byte", {22'd0, stkWrEn, stkWrHigh, stkWrByte}, {22'd0, 2'b11, ret[15:8]});
    setIn(noise);
    @(negedge clk);
    chk("R4 lo byte", {22'd0, stkWrEn, stkWrHigh, stkWrByte}, {22'd0, 2'b10, ret[7:0]});
    chk("R12 single ack", {31'd0, ackPulse}, 32'd0);
    if (kind == 3) begin
      @(negedge clk);
      chk("R7 first read", {15'd0, tblRdEn, tblAddr}, {15'd0, 1'b1, base});
      @(negedge clk);
      chk("R7 second read", {15'd0, tblRdEn, tblAddr}, {15'd0, 1'b1, base + 16'd1});
      @(negedge clk);
      chk("R12 not early", {30'd0, tblRdEn, tgtValid}, 32'd0);
    end
    @(negedge clk);
    chk(kind == 0 ? "R6 target" : (kind == 3 ? "R7 target" : "R8 target"),
        {15'd0, tgtValid, tgtPc}, {15'd0, 1'b1, tgt});
    setIn(1'b0);
    @(negedge clk);
    chk("R12 busy strobes ignored",
        {28'd0, tgtValid, ackPulse, iff1Out, halted}, {28'd0, 1'b0, 1'b0, mIff1, mHalt});
  endtask

  initial begin
    #(200000 * 5);
    nFail++; nChk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; pcIn = '0; irqVector = '0; pageReg = '0;
    setIn(1'b0);
    mIff1 = 0; mIff2 = 0; mHalt = 0; mMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 reset flags", {27'd0, iff1Out, iff2Out, halted, intMode}, 32'd0);
    chk("R11 reset outs", {12'd0, ackPulse, stkWrEn, tblRdEn, tgtValid, tgtPc}, 32'd0);

    // R1: disabled maskable request is refused
    boundary(16'h0100, 1, 8'hC7, 0, 0, 0, 0, 0, 2'd0, 8'h00, 0);
    // R9: request with enable in same boundary refused, then taken (mode 0, R8)
    boundary(16'h0101, 1, 8'hC7, 0, 1, 0, 0, 0, 2'd0, 8'h00, 0);
    boundary(16'h1234, 1, 8'hC7, 0, 0, 0, 0, 0, 2'd0, 8'h00, 1);
    // R10 + R8: mode 1 selected at accepting boundary
    boundary(16'h2000, 0, 8'h00, 0, 1, 0, 0, 0, 2'd0, 8'h00, 0);
    boundary(16'h2001, 1, 8'hFF, 0, 0, 0, 0, 1, 2'd1, 8'h00, 0);
    // R10: code 3 ignored
    boundary(16'h2002, 0, 8'h00, 0, 0, 0, 0, 1, 2'd3, 8'h00, 0);
    // R7 + R5: mode 2, halted, wrapping table at 0xFFFF
    boundary(16'h3000, 0, 8'h00, 0, 1, 0, 0, 1, 2'd2, 8'h00, 0);
    boundary(16'h4000, 0, 8'h00, 0, 0, 0, 1, 0, 2'd0, 8'h00, 0);
    boundary(16'h4000, 1, 8'hFF, 0, 0, 0, 0, 0, 2'd0, 8'hFF, 1);
    // R2 + R6: nmi while disabled and halted
    boundary(16'h5000, 0, 8'h00, 0, 0, 0, 1, 0, 2'd0, 8'h00, 0);
    boundary(16'h5000, 0, 8'h00, 1, 0, 0, 0, 0, 2'd0, 8'h00, 0);
    // R2 + R3: nmi beats irq while enabled, backup keeps 1
    boundary(16'h6000, 0, 8'h00, 0, 1, 0, 0, 0, 2'd0, 8'h00, 0);
    boundary(16'h6001, 1, 8'h10, 1, 0, 0, 0, 0, 2'd0, 8'h22, 1);
    // R9/R3: disable at boundary blocks request
    boundary(16'h7000, 0, 8'h00, 0, 1, 0, 0, 0, 2'd0, 8'h00, 0);
    boundary(16'h7001, 1, 8'h10, 0, 0, 1, 0, 0, 2'd0, 8'h00, 0);

    for (int i = 0; i < 400; i++) begin
      logic ei, di;
      ei = ($urandom % 5) == 0;
      di = !ei && (($urandom % 8) == 0);
      boundary(16'($urandom), 1'($urandom), 8'($urandom), ($urandom % 8) == 0,
               ei, di, ($urandom % 10) == 0, ($urandom % 5) == 0, 2'($urandom),
               8'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule